// File: doc/BRIEF.md
# Command Register Write-Interval Guard

This block sits between a host write port and a command register. It accepts a host write only when the previous command has had enough time to settle. For each accepted write it latches the command byte and emits a one-cycle command strobe. It then holds a busy flag for a guard interval, and any write that arrives during that interval is dropped.

A mode input selects what times the guard interval. In rate mode the interval is counted in ticks of the oversampling clock, which runs at eight times the line data rate. The base oversampling enable, `os_en_i`, is divided by a power of two chosen by the rate select, so the interval gets longer as the data rate falls. Two ticks give 800 ns at the fastest rate and 1.6 us at half that rate. In crystal mode the interval is counted in cycles of the system clock. With a 20 MHz crystal this gives a fixed 100 ns at every data rate.

A write that is dropped sets a sticky overrun flag. The flag stays set until the host clears it.

Top module: `cmd_write_guard`

## Requirements
- R1: While and after reset, `busy_o`, `cmd_pulse_o` and `ovr_o` are low and `cmd_o` is zero.
- R2: A write is accepted when `wr_i` is high at a clock edge while `busy_o` is low. After that edge, `cmd_pulse_o` is high for exactly one cycle and `cmd_o` holds `wr_data_i`.
- R3: `busy_o` goes high in the cycle after an accepted write.
- R4: In crystal mode (`mode_i` = 1), `busy_o` stays high for exactly XTAL_TICKS clock cycles and then falls.
- R5: In rate mode (`mode_i` = 0), the oversampling enable is divided by 2^`rate_sel_i`, where 0 is the fastest rate. The divider phase restarts at the accept edge. `busy_o` falls at the edge that samples the (OS_TICKS × 2^`rate_sel_i`)-th high `os_en_i` after the accept edge.
- R6: A write while `busy_o` is high produces no strobe, leaves `cmd_o` unchanged and does not restart the interval.
- R7: A write while `busy_o` is high sets `ovr_o` in the next cycle. `ovr_o` stays set until `ovr_clr_i` clears it. If a set and a clear happen in the same cycle, the set wins.
- R8: `mode_i` and `rate_sel_i` are captured at the accept edge. Changing them during the interval has no effect on its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_en_i | input | 1 | Base oversampling enable, one cycle per tick at the fastest rate |
| rate_sel_i | input | RATE_W | Data-rate divider select, 0 = fastest |
| mode_i | input | 1 | 1 = crystal-timed interval, 0 = rate-timed interval |
| wr_i | input | 1 | Host write strobe |
| wr_data_i | input | CMD_W | Host write data |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| cmd_pulse_o | output | 1 | One-cycle strobe for an accepted command |
| cmd_o | output | CMD_W | Last accepted command |
| busy_o | output | 1 | Guard interval in progress |
| ovr_o | output | 1 | Sticky flag: a write was dropped |

## Verification
The bench builds the block with its default parameters: two-tick intervals in both modes, an 8-bit command and a 2-bit rate select. With these values the crystal interval lasts 2 cycles, while the rate interval spans from 2 up to 16 oversampling pulses. The bench spaces those pulses several cycles apart, so an interval counted in the wrong clock, or a divider that starts at the wrong phase, shows up as a busy edge in the wrong cycle. Changing the mode and rate inputs in the middle of an interval, and asserting set and clear of the overrun flag in the same cycle, exercise the capture and priority rules.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  typedef enum logic {
    MODE_RATE = 1'b0,
    MODE_XTAL = 1'b1
  } clk_mode_e;
endpackage

// File: rtl/cwg_rate_div.sv
module cwg_rate_div #(
  parameter int RATE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              os_en_i,
  output logic              tick_o
);
  localparam int DIV_W = (1 << RATE_W) - 1;

  logic [RATE_W-1:0] rate_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [DIV_W-1:0]  lim;

  assign lim    = DIV_W'((1 << rate_q) - 1);
  assign tick_o = os_en_i && !start_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      // rate captured and phase restarted on accept
      rate_q <= rate_i;
      cnt_q  <= '0;
    end else if (os_en_i) begin
      cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end
  end

  // R5
  div_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
endmodule

// File: rtl/cwg_interval.sv
module cwg_interval
  import cwg_pkg::*;
#(
  parameter int OS_TICKS   = 2,
  parameter int XTAL_TICKS = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  clk_mode_e mode_i,
  input  logic      os_tick_i,
  output logic      busy_o
);
  localparam int MAX_T = (OS_TICKS > XTAL_TICKS) ? OS_TICKS : XTAL_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  clk_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             tick;

  assign tick   = (mode_q == MODE_XTAL) ? 1'b1 : os_tick_i;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RATE;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      mode_q <= mode_i;
      cnt_q  <= (mode_i == MODE_XTAL) ? CNT_W'(XTAL_TICKS) : CNT_W'(OS_TICKS);
      busy_q <= 1'b1;
    end else if (busy_q && tick) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  // R4
  cnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0 && cnt_q <= CNT_W'(MAX_T)));
  // R3
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
  // R4
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tick && cnt_q == CNT_W'(1)) |=> !busy_q);
endmodule

// File: rtl/cmd_write_guard.sv
module cmd_write_guard
  import cwg_pkg::*;
#(
  parameter int CMD_W      = 8,
  parameter int RATE_W     = 2,
  parameter int OS_TICKS   = 2,
  parameter int XTAL_TICKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_en_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              mode_i,
  input  logic              wr_i,
  input  logic [CMD_W-1:0]  wr_data_i,
  input  logic              ovr_clr_i,
  output logic              cmd_pulse_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              busy_o,
  output logic              ovr_o
);
  logic             busy;
  logic             accept;
  logic             os_tick;
  logic             pulse_q;
  logic             ovr_q;
  logic [CMD_W-1:0] cmd_q;

  assign accept = wr_i && !busy;

  cwg_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .rate_i  (rate_sel_i),
    .os_en_i (os_en_i),
    .tick_o  (os_tick)
  );

  cwg_interval #(.OS_TICKS(OS_TICKS), .XTAL_TICKS(XTAL_TICKS)) u_ivl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .mode_i    (clk_mode_e'(mode_i)),
    .os_tick_i (os_tick),
    .busy_o    (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      cmd_q   <= '0;
      ovr_q   <= 1'b0;
    end else begin
      pulse_q <= accept;
      if (accept) cmd_q <= wr_data_i;
      if (wr_i && busy) ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  assign cmd_pulse_o = pulse_q;
  assign cmd_o       = cmd_q;
  assign busy_o      = busy;
  assign ovr_o       = ovr_q;

  // R2
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  // R6
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy) |=> (!pulse_q && $stable(cmd_q)));
  // R7
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy) |=> ovr_q);
  // R2
  pulse_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> busy);
endmodule

// File: tb/cmd_write_guard_tb.sv
`timescale 1ns/1ps
module cmd_write_guard_tb;
  localparam int CLK_P = 50;
  localparam int OS_T  = 2;
  localparam int XT_T  = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       os_en_i = 1'b0;
  logic [1:0] rate_sel_i = '0;
  logic       mode_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       ovr_clr_i = 1'b0;
  logic       cmd_pulse_o;
  logic [7:0] cmd_o;
  logic       busy_o;
  logic       ovr_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  cmd_write_guard u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .os_en_i(os_en_i), .rate_sel_i(rate_sel_i),
    .mode_i(mode_i), .wr_i(wr_i), .wr_data_i(wr_data_i), .ovr_clr_i(ovr_clr_i),
    .cmd_pulse_o(cmd_pulse_o), .cmd_o(cmd_o), .busy_o(busy_o), .ovr_o(ovr_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] d, input logic os, input logic clr);
    @(negedge clk_i);
    wr_i = wr; wr_data_i = d; os_en_i = os; ovr_clr_i = clr;
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle_until_free();
    for (int i = 0; i < 200 && busy_o; i++) step(1'b0, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 pulse", cmd_pulse_o, 0);
    chk("R1 ovr", ovr_o, 0);
    chk("R1 cmd", cmd_o, 0);
  endtask

  task automatic t_xtal(input logic [7:0] d);
    int errs = 0;
    mode_i = 1'b1;
    step(1'b1, d, 1'b0, 1'b0);
    chk("R2 pulse", cmd_pulse_o, 1);
    chk("R2 cmd", cmd_o, d);
    chk("R3 busy rise", busy_o, 1);
    for (int j = 1; j <= XT_T; j++) begin
      step(1'b0, 8'h00, 1'b0, 1'b0);
      if (j == 1) chk("R2 pulse one cycle", cmd_pulse_o, 0);
      if (busy_o != (j < XT_T)) begin
        errs++;
        $display("FAIL R4 cycle %0d actual=%0d expected=%0d", j, busy_o, j < XT_T);
      end
    end
    chk("R4 crystal interval", errs, 0);
  endtask

  task automatic t_rate(input logic [1:0] rs, input int gap, input logic [7:0] d, input logic twiddle);
    int n = 0;
    int need = OS_T << rs;
    int errs = 0;
    mode_i = 1'b0; rate_sel_i = rs;
    step(1'b1, d, 1'b1, 1'b0);
    chk("R3 busy rise rate", busy_o, 1);
    if (twiddle) begin mode_i = 1'b1; rate_sel_i = ~rs; end
    for (int j = 0; j < 400 && n < need + 1; j++) begin
      logic os = (j % gap) == (gap - 1);
      step(1'b0, 8'h00, os, 1'b0);
      if (os) n++;
      if (busy_o != (n < need)) begin
        errs++;
        if (errs == 1) $display("FAIL %s rs=%0d pulses=%0d actual=%0d expected=%0d",
                                twiddle ? "R8" : "R5", rs, n, busy_o, n < need);
      end
    end
    chk(twiddle ? "R8 captured settings" : "R5 rate interval", errs, 0);
    mode_i = 1'b0; rate_sel_i = '0;
  endtask

  task automatic t_busy_write();
    mode_i = 1'b1;
    step(1'b1, 8'hA5, 1'b0, 1'b0);
    step(1'b1, 8'h3C, 1'b0, 1'b0);
    chk("R6 no pulse", cmd_pulse_o, 0);
    chk("R6 cmd kept", cmd_o, 8'hA5);
    chk("R7 ovr set", ovr_o, 1);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R6 not restarted", busy_o, 0);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R7 ovr sticky", ovr_o, 1);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R7 ovr cleared", ovr_o, 0);
    step(1'b1, 8'h11, 1'b0, 1'b0);
    step(1'b1, 8'h22, 1'b0, 1'b1);
    chk("R7 set beats clear", ovr_o, 1);
    chk("R6 cmd kept 2", cmd_o, 8'h11);
    idle_until_free();
    step(1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i); rst_ni = 1'b1;
    step(1'b0, 8'h00, 1'b0, 1'b0);
    t_reset();
    t_xtal(8'h5A);
    t_xtal(8'hFF);
    t_rate(2'd0, 3, 8'h01, 1'b0);
    t_rate(2'd1, 3, 8'h02, 1'b0);
    t_rate(2'd3, 2, 8'h03, 1'b0);
    t_rate(2'd2, 5, 8'h04, 1'b0);
    t_rate(2'd1, 4, 8'h05, 1'b1);
    chk("R2 cmd after rate", cmd_o, 8'h05);
    t_busy_write();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule